// File: doc/BRIEF.md
# Weekly Alarm Time Comparator

This block keeps a weekly alarm setting for a real-time clock: an alarm minute, an alarm hour and a seven-bit set of weekdays. Once per minute the timekeeping logic pulses an update strobe. On that strobe the block compares the stored setting with the running BCD minute, BCD hour and day-of-week code. When all three agree, it sets a sticky alarm flag.

The flag stays set until software clears it by writing the status offset. While the flag is set and the alarm enable input is high, an active-low interrupt line is driven low. The hour setting follows the clock's mode. In 24-hour mode it is a plain BCD hour from 00 to 23. In 12-hour mode bit 5 marks p.m. and the lower five bits hold 01 to 12, with midnight stored as 12h and noon as 32h, which is the encoding the time counter uses. A stored setting that names a time that cannot exist never matches.

The registers are not reset, so software must program them before it relies on the alarm.

Top module: `wkalarm_cmp`

## Requirements
- R1: Reading offset 8h returns the alarm minute and offset 9h returns the alarm hour. Offset Ah returns the weekday mask and offset Bh returns {7'b0, flag}. Every other offset reads 00h. Reads are combinational from the address.
- R2: The minute register keeps write bits 6..0. Bit 7 ignores writes and always reads 0.
- R3: The hour register keeps write bits 5..0. Bits 7 and 6 always read 0.
- R4: On a cycle with the update strobe high, the flag sets at that clock edge when three conditions hold. The stored minute must equal the current minute and the stored hour must equal the current hour. The mask bit indexed by the day code (0..6) must also be 1. Day code 7 never matches.
- R5: When the weekday mask is 00h, the flag is never set.
- R6: Without the update strobe, no input combination sets the flag.
- R7: A stored time that cannot exist never matches. Each of the following counts as such a time:
  - a minute with tens above 5 or units above 9;
  - in 24-hour mode, an hour above 23 or with units above 9;
  - in 12-hour mode, an hour whose bits 4..0 are outside 01..12, with bit 5 as the p.m. flag.
- R8: The flag resets to 0 and holds until a write to offset Bh with data bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged. If a match and a clearing write fall in the same cycle, the flag ends up set.
- R9: `alm_irq_n` is 0 exactly while the flag is 1 and `alm_en` is 1. Otherwise it is 1.
- R10: In 12-hour mode (`mode_24` = 0), a stored hour of 12h matches a current hour of 12h (midnight), and a stored hour of 32h matches a current hour of 32h (noon).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_addr |
| now_min | input | 7 | Current BCD minute |
| now_hour | input | 6 | Current BCD hour, encoded for the current mode |
| mode_24 | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode |
| now_dow | input | 3 | Current day-of-week code, 0..6 |
| min_tick | input | 1 | One-cycle pulse, once per minute |
| alm_en | input | 1 | Allows the flag to drive the interrupt |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq_n | output | 1 | Active-low interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. From then on the read data reflects it combinationally within the same cycle. The bench therefore reads back one cycle after each write, at the falling edge.

A match or a clearing write changes the flag at the edge that samples the strobe. The interrupt follows the flag and `alm_en` with no added delay. A change of `alm_en` alone therefore shows on `alm_irq_n` before the next edge.

A behavioural model in the bench updates its flag on each rising edge. It is compared with the flag, the interrupt and the read data at every falling edge, once the inputs have settled.

// File: rtl/wka_pkg.sv
`timescale 1ns/1ps
package wka_pkg;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DAYS   = 7;

  // minute is BCD 00..59
  function automatic logic bcd_min_ok(input logic [MIN_W-1:0] m);
    return (m[3:0] < 4'd10) && (m[6:4] < 3'd6);
  endfunction

  // hour in 24h mode: 00..23 ; in 12h mode: bit5 = pm, bits4..0 = 01..12
  function automatic logic bcd_hour_ok(input logic [HOUR_W-1:0] h, input logic is24);
    logic units_ok;
    units_ok = (h[3:0] < 4'd10);
    if (is24)
      return units_ok && ((h[5:4] < 2'd2) || (h[5:4] == 2'd2 && h[3:0] < 4'd4));
    else
      return units_ok && ((!h[4] && h[3:0] != 4'd0) || (h[4] && h[3:0] < 4'd3));
  endfunction
endpackage

// File: rtl/wka_regs.sv
`timescale 1ns/1ps
module wka_regs
  import wka_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MIN_OFS  = 'h8,
  parameter logic [ADDR_W-1:0] HOUR_OFS = 'h9,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hA
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [MIN_W-1:0]  alm_min,
  output logic [HOUR_W-1:0] alm_hour,
  output logic [DAYS-1:0]   alm_mask
);
  // alarm settings are deliberately not reset
  logic wr_min, wr_hour, wr_mask;
  assign wr_min  = we && (addr == MIN_OFS);
  assign wr_hour = we && (addr == HOUR_OFS);
  assign wr_mask = we && (addr == MASK_OFS);

  always_ff @(posedge clk) begin
    if (wr_min)  alm_min  <= wdata[MIN_W-1:0];
    if (wr_hour) alm_hour <= wdata[HOUR_W-1:0];
    if (wr_mask) alm_mask <= wdata[DAYS-1:0];
  end
endmodule

// File: rtl/wka_match.sv
`timescale 1ns/1ps
module wka_match
  import wka_pkg::*;
#(
  parameter int DOW_W = 3
) (
  input  logic              tick,
  input  logic              mode_24,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [DOW_W-1:0]  now_dow,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [DAYS-1:0]   alm_mask,
  output logic              min_ok,
  output logic              hour_ok,
  output logic              day_ok,
  output logic              hit
);
  logic [DAYS-1:0] day_sel;

  generate
    for (genvar d = 0; d < DAYS; d++) begin : g_day
      assign day_sel[d] = alm_mask[d] && (now_dow == DOW_W'(d));
    end
  endgenerate

  assign min_ok  = bcd_min_ok(alm_min);
  assign hour_ok = bcd_hour_ok(alm_hour, mode_24);
  assign day_ok  = |day_sel;
  assign hit     = tick && min_ok && hour_ok && day_ok
                   && (alm_min == now_min) && (alm_hour == now_hour);
endmodule

// File: rtl/wka_flag.sv
`timescale 1ns/1ps
module wka_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;   // a new match outranks a clear
    else if (clr) flag <= 1'b0;
  end

  assign irq_n = !(flag && en);

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R8
endmodule

// File: rtl/wkalarm_cmp.sv
`timescale 1ns/1ps
module wkalarm_cmp
  import wka_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DOW_W  = 3,
  parameter logic [ADDR_W-1:0] MIN_OFS  = 'h8,
  parameter logic [ADDR_W-1:0] HOUR_OFS = 'h9,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hA,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic              mode_24,
  input  logic [DOW_W-1:0]  now_dow,
  input  logic              min_tick,
  input  logic              alm_en,
  output logic              alm_flag,
  output logic              alm_irq_n
);
  logic [MIN_W-1:0]  alm_min;
  logic [HOUR_W-1:0] alm_hour;
  logic [DAYS-1:0]   alm_mask;
  logic min_ok, hour_ok, day_ok, match_hit, flag_clr;

  wka_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MIN_OFS(MIN_OFS), .HOUR_OFS(HOUR_OFS), .MASK_OFS(MASK_OFS)
  ) u_regs (
    .clk(clk), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask)
  );

  wka_match #(.DOW_W(DOW_W)) u_match (
    .tick(min_tick), .mode_24(mode_24),
    .now_min(now_min), .now_hour(now_hour), .now_dow(now_dow),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask),
    .min_ok(min_ok), .hour_ok(hour_ok), .day_ok(day_ok), .hit(match_hit)
  );

  assign flag_clr = reg_we && (reg_addr == CTL_OFS) && !reg_wdata[0];

  wka_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(match_hit), .clr(flag_clr),
    .en(alm_en), .flag(alm_flag), .irq_n(alm_irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      MIN_OFS:  reg_rdata[MIN_W-1:0]  = alm_min;
      HOUR_OFS: reg_rdata[HOUR_W-1:0] = alm_hour;
      MASK_OFS: reg_rdata[DAYS-1:0]   = alm_mask;
      CTL_OFS:  reg_rdata[0]          = alm_flag;
      default:  reg_rdata = '0;
    endcase
  end

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(min_tick)); // R6
  AST_MASK_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_mask == '0) && !alm_flag |=> !alm_flag); // R5
  AST_BAD_MIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !bcd_min_ok(alm_min) && !alm_flag |=> !alm_flag); // R7
  AST_HOUR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == HOUR_OFS) |-> (reg_rdata[7:6] == 2'b00)); // R3
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_flag |-> alm_irq_n); // R9
endmodule

// File: tb/wkalarm_cmp_tb.sv
`timescale 1ns/1ps
module wkalarm_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic mode_24 = 1'b1;
  logic [2:0] now_dow = '0;
  logic min_tick = 1'b0;
  logic alm_en = 1'b0;
  logic alm_flag, alm_irq_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  wkalarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .now_min(now_min),
    .now_hour(now_hour), .mode_24(mode_24), .now_dow(now_dow),
    .min_tick(min_tick), .alm_en(alm_en), .alm_flag(alm_flag),
    .alm_irq_n(alm_irq_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  int m_min, m_hour, m_mask;
  bit k_min = 0, k_hour = 0, k_mask = 0;
  bit m_flag = 0;

  function automatic bit ok_min(int v);
    return ((v / 16) <= 5) && ((v % 16) <= 9);
  endfunction

  function automatic bit ok_hour(int v, bit h24);
    int tens, units, val;
    units = v % 16;
    if (units > 9) return 0;
    if (h24) begin
      tens = v / 16;
      val = tens * 10 + units;
      return val <= 23;
    end
    tens = (v / 16) % 2;
    val = tens * 10 + units;
    return (val >= 1) && (val <= 12);
  endfunction

  function automatic bit model_hit();
    if (!min_tick || now_dow > 6) return 0;
    if (!ok_min(m_min) || !ok_hour(m_hour, mode_24)) return 0;
    return (m_min == int'(now_min)) && (m_hour == int'(now_hour))
           && (((m_mask >> now_dow) & 1) == 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_flag <= 0;
    else if (model_hit()) m_flag <= 1;
    else if (reg_we && reg_addr == 4'hB && !reg_wdata[0]) m_flag <= 0;
    if (reg_we) begin
      if (reg_addr == 4'h8) begin m_min  <= reg_wdata % 128; k_min  <= 1; end
      if (reg_addr == 4'h9) begin m_hour <= reg_wdata % 64;  k_hour <= 1; end
      if (reg_addr == 4'hA) begin m_mask <= reg_wdata % 128; k_mask <= 1; end
    end
  end

  function automatic int exp_rdata();
    case (reg_addr)
      4'h8: return k_min  ? m_min  : -1;
      4'h9: return k_hour ? m_hour : -1;
      4'hA: return k_mask ? m_mask : -1;
      4'hB: return int'(m_flag);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      chk("R4 flag vs model", int'(alm_flag), int'(m_flag));
      chk("R9 irq vs model", int'(alm_irq_n), int'(!(m_flag && alm_en)));
      e = exp_rdata();
      if (e >= 0) chk("R1 rdata vs model", int'(reg_rdata), e);
    end
  end

  task automatic cycle();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; cycle(); reg_we = 0;
  endtask

  task automatic tick();
    min_tick = 1; cycle(); min_tick = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag, int exp);
    reg_addr = a; #1; chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic clear_flag();
    wr(4'hB, 8'h00);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1; cycle();
    chk("R8 reset flag", int'(alm_flag), 0);
    chk("R9 reset irq", int'(alm_irq_n), 1);

    // program in 24-hour mode: 14:30 on day 2
    mode_24 = 1; alm_en = 1;
    wr(4'h8, 8'h30); wr(4'h9, 8'h14); wr(4'hA, 8'h04);
    rd(4'h8, "R1 minute readback", 'h30);
    rd(4'h9, "R1 hour readback", 'h14);
    rd(4'hA, "R1 mask readback", 'h04);
    rd(4'hB, "R1 status readback", 0);
    rd(4'h5, "R1 unmapped offset", 0);

    now_min = 7'h30; now_hour = 6'h14; now_dow = 3'd2;
    repeat (3) cycle();
    chk("R6 no tick no flag", int'(alm_flag), 0);
    tick();
    chk("R4 match sets flag", int'(alm_flag), 1);
    chk("R9 irq low", int'(alm_irq_n), 0);
    alm_en = 0; #1;
    chk("R9 irq gated by enable", int'(alm_irq_n), 1);
    alm_en = 1; #1;
    rd(4'hB, "R8 status shows flag", 1);
    wr(4'hB, 8'h01);
    chk("R8 write bit0=1 keeps flag", int'(alm_flag), 1);
    clear_flag();
    chk("R8 write bit0=0 clears", int'(alm_flag), 0);

    now_dow = 3'd3; tick();
    chk("R4 wrong day", int'(alm_flag), 0);
    wr(4'hA, 8'h7F); now_dow = 3'd7; tick();
    chk("R4 day code 7", int'(alm_flag), 0);
    now_dow = 3'd2; wr(4'hA, 8'h00); tick();
    chk("R5 empty mask", int'(alm_flag), 0);
    wr(4'hA, 8'h7F);

    wr(4'h8, 8'hDA);
    rd(4'h8, "R2 bit7 ignored", 'h5A);
    now_min = 7'h5A; tick();
    chk("R7 bad minute", int'(alm_flag), 0);
    wr(4'h8, 8'h30); now_min = 7'h30;
    wr(4'h9, 8'h24); now_hour = 6'h24; tick();
    chk("R7 hour 24 in 24h", int'(alm_flag), 0);
    wr(4'h9, 8'hFF);
    rd(4'h9, "R3 top bits zero", 'h3F);

    // 12-hour mode
    mode_24 = 0;
    wr(4'h9, 8'h12); now_hour = 6'h12; tick();
    chk("R10 midnight 12h", int'(alm_flag), 1);
    clear_flag();
    wr(4'h9, 8'h32); now_hour = 6'h32; tick();
    chk("R10 noon 32h", int'(alm_flag), 1);
    clear_flag();
    wr(4'h9, 8'h13); now_hour = 6'h13; tick();
    chk("R7 hour 13 in 12h", int'(alm_flag), 0);
    wr(4'h9, 8'h00); now_hour = 6'h00; tick();
    chk("R7 hour 00 in 12h", int'(alm_flag), 0);

    // match and clear in the same cycle
    wr(4'h9, 8'h12); now_hour = 6'h12;
    reg_addr = 4'hB; reg_wdata = 8'h00; reg_we = 1; min_tick = 1;
    cycle();
    reg_we = 0; min_tick = 0;
    chk("R8 set beats clear", int'(alm_flag), 1);
    clear_flag();

    // random traffic checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 10;
      reg_we = 0;
      if (r < 2) begin
        reg_addr = 4'h8 + 4'($urandom % 4);
        reg_wdata = ($urandom % 4 == 0) ? 8'($urandom)
                  : 8'(($urandom % 3) * 16 + ($urandom % 10));
        if (reg_addr == 4'hA) reg_wdata = 8'($urandom);
        reg_we = 1;
      end else begin
        reg_addr = 4'($urandom % 16);
      end
      now_min  = ($urandom % 2) ? 7'(m_min)  : 7'(($urandom % 6) * 16 + ($urandom % 10));
      now_hour = ($urandom % 2) ? 6'(m_hour) : 6'($urandom);
      now_dow  = 3'($urandom);
      if ($urandom % 50 == 0) mode_24 = ~mode_24;
      if ($urandom % 20 == 0) alm_en = ~alm_en;
      min_tick = ($urandom % 3 == 0);
      cycle();
    end
    reg_we = 0; min_tick = 0;
    cycle();
    finish_run();
  end
endmodule